// File: doc/BRIEF.md
# Page write buffer with timed program cycle

This block sits behind a two-wire serial slave engine in a small non-volatile memory. The engine hands it the word address of a write transfer and then each received data byte. The block keeps those bytes in a 16-entry page buffer. Each entry has its own valid bit. A write can start at any offset inside a 16-byte aligned page. Each accepted byte advances only the low four address bits, so the address wraps inside the page and never reaches the next one.

When a STOP arrives after at least one accepted data byte, the block enters a program interval of fixed length. During that interval it writes every valid buffer entry to the array port, one entry per cycle, in ascending slot order. Entries that were never received are not written. While the interval runs, the busy flag tells the slave engine not to acknowledge its own slave address, and the block ignores every input strobe. A master can therefore poll with address bytes until it gets an acknowledge. A START that arrives after data but before STOP throws the buffered bytes away.

A protect input guards the upper half of the array. When it is high and the word address has its top bit set, each data byte is refused. The data-acknowledge decision is low, the byte is not buffered and no program interval follows.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy_o and mem_we_o are low and addr_o is 0x00.
- R2: An accepted data byte raises data_ack_o in its strobe cycle. It advances addr_o[3:0] by one, wrapping from 0xF to 0x0, and addr_o[7:4] stays unchanged.
- R3: When more than 16 bytes arrive in one transfer, a later byte replaces the earlier one in the same slot, and each slot is written at most once per commit.
- R4: A commit writes only the slots that received a byte. The writes use mem_addr_o = {addr_o[7:4], slot}, go in ascending slot order, and start in the cycle after the STOP edge, with slot k in cycle k.
- R5: A STOP with no accepted data byte since the last START or address load does not start a program interval.
- R6: After a qualifying STOP, busy_o is high for exactly PROG_CYCLES cycles.
- R7: While busy_o is high, address loads, data strobes, START and STOP have no effect: addr_o holds, data_ack_o stays low and no further commit follows.
- R8: With wp_i high and addr_o[7] = 1, a data byte gets data_ack_o low, addr_o does not move, and the following STOP starts no program interval.
- R9: With wp_i low, bytes in the upper half are accepted and committed. With wp_i high, bytes in the lower half are still accepted and committed.
- R10: A START after data bytes and before STOP discards the buffered bytes, so the next STOP starts no program interval.
- R11: After a commit, addr_o holds the last accepted address plus one, wrapped inside the page.
- R12: A data byte strobed in the same cycle as STOP is accepted and included in that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START seen on the bus (one-cycle pulse) |
| stop_i | input | 1 | STOP seen on the bus (one-cycle pulse) |
| waddr_load_i | input | 1 | Load the word address |
| waddr_i | input | 8 | Word address value |
| byte_vld_i | input | 1 | Data byte received |
| byte_i | input | 8 | Data byte value |
| wp_i | input | 1 | Protect the upper half of the array |
| data_ack_o | output | 1 | Acknowledge decision for the current data byte |
| busy_o | output | 1 | Program interval running; do not acknowledge the slave address |
| addr_o | output | 8 | Shared address counter |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The functions that can fall in the same cycle are buffer capture and commit launch: a data strobe and a STOP can be asserted on the same clock edge. The bench raises byte_vld_i and stop_i together after one earlier byte. It then expects both slots to be written in order, with the program interval at full length. A second overlap drives address loads, data strobes, START and STOP while the block is busy. Every one must be ignored, and that is judged at the ports by addr_o, data_ack_o, busy_o and the absence of stray array writes.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  localparam int unsigned PW_ADDR_W      = 8;
  localparam int unsigned PW_DATA_W      = 8;
  localparam int unsigned PW_PAGE_BYTES  = 16;
  localparam int unsigned PW_PROG_CYCLES = 2000;
endpackage

// File: rtl/pw_addr_ctr.sv
module pw_addr_ctr #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_addr_i;
    else if (inc_i)   addr_q[OFF_W-1:0] <= addr_q[OFF_W-1:0] + 1'b1; // wrap inside page
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned OFF_W      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [OFF_W-1:0]      wr_slot_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [OFF_W-1:0]      rd_slot_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [PAGE_BYTES-1:0] valid_o
);
  logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wr_slot_i == OFF_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[s] <= '0;
        vld_q[s] <= 1'b0;
      end else begin
        if (hit)        vld_q[s] <= 1'b1;
        else if (clr_i) vld_q[s] <= 1'b0;
        if (hit)        mem_q[s] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_slot_i];
  assign valid_o   = vld_q;
endmodule

// File: rtl/pw_prog_timer.sv
module pw_prog_timer #(
  parameter int unsigned PROG_CYCLES = 2000,
  parameter int unsigned CNT_W       = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter int unsigned ADDR_W      = PW_ADDR_W,
  parameter int unsigned DATA_W      = PW_DATA_W,
  parameter int unsigned PAGE_BYTES  = PW_PAGE_BYTES,
  parameter int unsigned PROG_CYCLES = PW_PROG_CYCLES  // must be >= PAGE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              waddr_load_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              wp_i,
  output logic              data_ack_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;
  localparam int unsigned CNT_W  = $clog2(PROG_CYCLES);

  logic                  busy, done, idle, prot, byte_ok, load_ok, clr, go;
  logic [CNT_W-1:0]      cnt;
  logic [OFF_W-1:0]      slot, prog_slot;
  logic [PAGE_BYTES-1:0] valid, mask_after;
  logic [DATA_W-1:0]     rd_data;

  assign idle      = !busy;
  assign slot      = addr_o[OFF_W-1:0];
  assign prog_slot = cnt[OFF_W-1:0];
  assign prot      = wp_i && addr_o[ADDR_W-1];
  assign load_ok   = waddr_load_i && idle;
  assign byte_ok   = byte_vld_i && idle && !waddr_load_i && !prot;
  assign clr       = (idle && (start_i || waddr_load_i)) || done;

  // a byte strobed alongside STOP still counts toward the commit
  always_comb begin
    mask_after = valid;
    if (byte_ok) mask_after[slot] = 1'b1;
  end
  assign go = idle && stop_i && !start_i && (|mask_after);

  pw_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_ok),
    .load_addr_i (waddr_i),
    .inc_i       (byte_ok),
    .addr_o      (addr_o)
  );

  pw_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_i      (byte_ok),
    .wr_slot_i (slot),
    .wr_data_i (byte_i),
    .rd_slot_i (prog_slot),
    .rd_data_o (rd_data),
    .valid_o   (valid)
  );

  pw_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .busy_o (busy),
    .done_o (done),
    .cnt_o  (cnt)
  );

  assign busy_o      = busy;
  assign data_ack_o  = byte_ok;
  assign mem_we_o    = busy && (cnt < CNT_W'(PAGE_BYTES)) && valid[prog_slot];
  assign mem_addr_o  = {addr_o[ADDR_W-1 -: PAGE_W], prog_slot};
  assign mem_wdata_o = rd_data;
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              waddr_load_i,
  input logic              byte_vld_i,
  input logic              wp_i,
  input logic              data_ack_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ack_o |-> byte_vld_i); // R2

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ack_o && !waddr_load_i) |=> addr_o[ADDR_W-1:4] == $past(addr_o[ADDR_W-1:4])); // R2

  AST_WE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R4

  AST_WE_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[ADDR_W-1:4] == addr_o[ADDR_W-1:4]); // R4

  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i)); // R6

  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_ack_o); // R7

  AST_ADDR_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> addr_o == $past(addr_o)); // R7

  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && wp_i && addr_o[ADDR_W-1] && !waddr_load_i) |=> addr_o == $past(addr_o)); // R8
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .waddr_load_i (waddr_load_i),
  .byte_vld_i   (byte_vld_i),
  .wp_i         (wp_i),
  .data_ack_o   (data_ack_o),
  .busy_o       (busy_o),
  .addr_o       (addr_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o)
);

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
  localparam int P = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, stop_i = 0, waddr_load_i = 0, byte_vld_i = 0, wp_i = 0;
  logic [7:0] waddr_i = 0, byte_i = 0;
  logic       data_ack_o, busy_o, mem_we_o;
  logic [7:0] addr_o, mem_addr_o, mem_wdata_o;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  m_addr;
  logic [7:0]  m_buf[16];
  logic [15:0] m_vld;

  always #2 clk = ~clk;

  eeprom_page_writer #(.PROG_CYCLES(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
    .waddr_load_i(waddr_load_i), .waddr_i(waddr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .wp_i(wp_i), .data_ack_o(data_ack_o), .busy_o(busy_o),
    .addr_o(addr_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every array write must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({mem_addr_o, mem_wdata_o} == e, "R4 write item", {mem_addr_o, mem_wdata_o}, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_load(input logic [7:0] a);
    waddr_load_i = 1; waddr_i = a; step(); waddr_load_i = 0;
    m_addr = a; m_vld = '0;
  endtask

  task automatic do_start();
    start_i = 1; step(); start_i = 0; m_vld = '0;
  endtask

  task automatic do_byte(input logic [7:0] d, input bit exp_ack, input string req);
    byte_vld_i = 1; byte_i = d;
    @(negedge clk);
    chk(data_ack_o == exp_ack, req, data_ack_o, exp_ack);
    step(); byte_vld_i = 0;
    if (exp_ack) begin
      m_buf[m_addr[3:0]] = d; m_vld[m_addr[3:0]] = 1'b1;
      m_addr[3:0] = m_addr[3:0] + 1'b1;
    end
  endtask

  task automatic push_commit();
    for (int i = 0; i < 16; i++)
      if (m_vld[i]) exp_q.push_back({m_addr[7:4], 4'(i), m_buf[i]});
    m_vld = '0;
  endtask

  task automatic wait_prog(input string req);
    int n = 0;
    @(negedge clk);
    while (busy_o && n < 10*P) begin n++; @(negedge clk); end
    chk(n == P, req, n, P);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    step();
  endtask

  task automatic do_stop(input bit expect_prog, input string req);
    if (expect_prog) push_commit();
    stop_i = 1; step(); stop_i = 0;
    if (expect_prog) wait_prog(req);
    else begin
      @(negedge clk); chk(busy_o == 0, req, busy_o, 0); step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_vld = '0; m_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy_o == 0 && mem_we_o == 0, "R1 reset outputs", {busy_o, mem_we_o}, 0);
    chk(addr_o == 8'h00, "R1 reset addr", addr_o, 0);
    rst_n = 1; step();

    // single byte
    do_start(); do_load(8'h23);
    do_byte(8'hA5, 1, "R2 ack");
    @(negedge clk); chk(addr_o == 8'h24, "R2 increment", addr_o, 8'h24); step();
    do_stop(1, "R6 busy length");
    @(negedge clk); chk(addr_o == 8'h24, "R11 addr after commit", addr_o, 8'h24); step();

    // wrap inside page, sparse slots
    do_start(); do_load(8'h3E);
    do_byte(8'h01, 1, "R2 ack"); do_byte(8'h02, 1, "R2 ack");
    @(negedge clk); chk(addr_o == 8'h30, "R2 wrap", addr_o, 8'h30); step();
    do_byte(8'h03, 1, "R2 ack"); do_byte(8'h04, 1, "R2 ack");
    do_stop(1, "R4 sparse commit");
    @(negedge clk); chk(addr_o == 8'h32, "R11 wrapped addr", addr_o, 8'h32); step();

    // overrun: 18 bytes into one page
    do_start(); do_load(8'h50);
    for (int i = 0; i < 18; i++) do_byte(8'(8'h80 + i), 1, "R3 ack");
    do_stop(1, "R3 overrun commit");
    @(negedge clk); chk(addr_o == 8'h52, "R11 overrun addr", addr_o, 8'h52); step();

    // STOP without data
    do_start(); do_load(8'h10);
    do_stop(0, "R5 no data no program");

    // inputs ignored while busy
    do_start(); do_load(8'h44); do_byte(8'h5A, 1, "R7 setup");
    push_commit();
    stop_i = 1; step(); stop_i = 0;
    waddr_load_i = 1; waddr_i = 8'h99; step(); waddr_load_i = 0;
    byte_vld_i = 1; byte_i = 8'hEE;
    @(negedge clk); chk(data_ack_o == 0, "R7 no ack while busy", data_ack_o, 0);
    step(); byte_vld_i = 0;
    start_i = 1; step(); start_i = 0;
    stop_i = 1; step(); stop_i = 0;
    @(negedge clk); chk(addr_o == 8'h45, "R7 addr held", addr_o, 8'h45);
    chk(busy_o == 1, "R7 still busy", busy_o, 1);
    while (busy_o) @(negedge clk);
    @(negedge clk); chk(busy_o == 0, "R7 no second commit", busy_o, 0);
    chk(exp_q.size() == 0, "R7 writes", exp_q.size(), 0);
    step();

    // write protect
    wp_i = 1;
    do_start(); do_load(8'h85);
    do_byte(8'h77, 0, "R8 nack protected");
    @(negedge clk); chk(addr_o == 8'h85, "R8 addr held", addr_o, 8'h85); step();
    do_stop(0, "R8 no program");
    do_start(); do_load(8'h05);
    do_byte(8'h66, 1, "R9 lower half with protect");
    do_stop(1, "R9 lower commit");
    wp_i = 0;
    do_start(); do_load(8'hF0);
    do_byte(8'h55, 1, "R9 upper half unprotected");
    do_stop(1, "R9 upper commit");

    // START discards
    do_start(); do_load(8'h60);
    do_byte(8'h12, 1, "R10 ack"); do_byte(8'h34, 1, "R10 ack");
    do_start();
    do_stop(0, "R10 discarded");

    // byte and STOP in the same cycle
    do_start(); do_load(8'h70);
    do_byte(8'h11, 1, "R12 first");
    byte_vld_i = 1; byte_i = 8'h22; stop_i = 1;
    @(negedge clk); chk(data_ack_o == 1, "R12 ack with stop", data_ack_o, 1);
    m_buf[1] = 8'h22; m_vld[1] = 1'b1; m_addr = 8'h72;
    push_commit();
    step(); byte_vld_i = 0; stop_i = 0;
    wait_prog("R12 commit length");
    @(negedge clk); chk(addr_o == 8'h72, "R12 addr", addr_o, 8'h72);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule